// File: doc/BRIEF.md
# 66-Bit Block Alignment Synchronizer

This block searches for, and then keeps track of, the 66-bit block boundary in a received serial stream. An upstream gearbox presents one candidate block at a time. For each one it supplies the block's 2-bit sync header and a strobe that marks it as present. A sync header is meaningful only when its two bits differ. While no alignment is held, the block counts consecutive well-formed headers. Each malformed header makes it ask the gearbox to move the boundary by one bit. Once alignment has been held for a full run of good headers, the block reports lock.

While locked, the block counts malformed headers inside fixed windows of received headers. A handful of errors does not break lock. Lock is dropped only when a window collects the error limit, and the block then returns to searching with a slip. Each malformed header seen under lock raises an error flag that is held for three cycles, so that a slower clock domain can catch it. Synchronizing that flag and the lock flag is left to the consumer. A separate manual slip input lets software or a higher layer force a one-bit slip on each rising edge.

Top module: `hdr_block_sync`

## Requirements
- R1: A header sampled with `hdr_vld` high is good when `hdr` is 2'b01 or 2'b10, and bad when it is 2'b00 or 2'b11.
- R2: While searching, `blk_lock` goes high on the clock edge that samples the 64th consecutive good header, and not one header earlier.
- R3: While searching, each bad header sets `slip_req` high for exactly the cycle after the sampling edge. It also restarts the good-header count, so 64 more good headers are needed for lock.
- R4: While locked, 15 bad headers within one 64-header window leave `blk_lock` high. The 16th bad header in the same window clears `blk_lock` and raises `slip_req` on the same edge.
- R5: The bad-header count under lock starts again at zero after every 64 headers that follow lock. Bad headers in different windows therefore do not add up.
- R6: Each bad header sampled while locked, unless it is the one that drops lock, drives `hdr_err` high for exactly 3 cycles after its sampling edge. A further bad header restarts the 3 cycles.
- R7: `hdr_err` is never high while `blk_lock` is low. The header that drops lock produces no error pulse.
- R8: A rising edge on `man_slip` gives a one-cycle `slip_req`. Holding `man_slip` high gives no further slips. While searching, the rising edge also restarts the good-header count. While locked, it does not change `blk_lock`.
- R9: When `hdr_vld` is low, `hdr` is ignored: no slip request, no change to lock and no count progress.
- R10: Driving `arst_n` low clears `blk_lock`, `hdr_err`, `slip_req` and all counters at once, without waiting for a clock edge. Release is synchronized to `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hdr_vld | input | 1 | A candidate block header is present this cycle |
| hdr | input | 2 | Sync header of the candidate block |
| man_slip | input | 1 | Manual slip request, acted on at its rising edge |
| blk_lock | output | 1 | Block alignment is held |
| hdr_err | output | 1 | Bad header seen under lock, stretched to 3 cycles |
| slip_req | output | 1 | One-cycle request to shift the gearbox alignment by one bit |

## Verification
Several relations are checked on every cycle. A fall of lock always comes with a slip. A bad header while searching is always followed by a slip. The error flag never appears without lock. An idle strobe never changes lock. Lock only rises after a good header, and the stretch timer counts down steadily. Other behaviour needs whole scenarios and is shown only by the bench. This covers the exact 64th-header acquisition point and the 15-versus-16 error threshold. It also covers the window reset that keeps errors in separate windows apart, the exact 3-cycle stretch with retrigger, and manual slip edge detection in both states.

// File: rtl/hsync_pkg.sv
package hsync_pkg;
  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_LOCKED = 1'b1
  } sync_st_e;

  // a sync header is meaningful only when its two bits differ
  function automatic logic hdr_ok(input logic [1:0] h);
    return h[1] ^ h[0];
  endfunction
endpackage

// File: rtl/hsync_rst_sync.sv
module hsync_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/hsync_acq.sv
module hsync_acq #(
  parameter int LOCK_CNT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ok,
  input  logic restart,
  output logic done
);
  localparam int W = (LOCK_CNT > 2) ? $clog2(LOCK_CNT) : 1;
  localparam logic [W-1:0] LAST = W'(LOCK_CNT - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    done  = 1'b0;
    if (restart) begin
      cnt_d = '0;
    end else if (en) begin
      if (!ok) begin
        cnt_d = '0;
      end else if (cnt_q == LAST) begin
        done  = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  assign cnt_en = restart | en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R3: a bad header during search leaves the run empty
  p_bad_restarts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ok) |=> (cnt_q == '0));
endmodule

// File: rtl/hsync_mon.sv
module hsync_mon #(
  parameter int WIN_LEN   = 64,
  parameter int ERR_LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bad,
  input  logic clr,
  output logic loss
);
  localparam int WW = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
  localparam int EW = (ERR_LIMIT > 2) ? $clog2(ERR_LIMIT) : 1;
  localparam logic [WW-1:0] WLAST = WW'(WIN_LEN - 1);
  localparam logic [EW-1:0] ELAST = EW'(ERR_LIMIT - 1);

  logic [WW-1:0] win_q, win_d;
  logic [EW-1:0] bad_q, bad_d;
  logic          upd;

  always_comb begin
    win_d = win_q;
    bad_d = bad_q;
    loss  = 1'b0;
    if (clr) begin
      win_d = '0;
      bad_d = '0;
    end else if (en) begin
      if (bad && (bad_q == ELAST)) begin
        loss  = 1'b1;
        win_d = '0;
        bad_d = '0;
      end else if (win_q == WLAST) begin
        win_d = '0;
        bad_d = '0;
      end else begin
        win_d = win_q + 1'b1;
        bad_d = bad_q + EW'(bad);
      end
    end
  end

  assign upd = clr | en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      bad_q <= '0;
    end else if (upd) begin
      win_q <= win_d;
      bad_q <= bad_d;
    end
  end

  // R4: a loss event leaves both counters empty for the next search
  p_loss_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    loss |=> (bad_q == '0 && win_q == '0));

  // R5: a window-closing header restarts the error count
  p_window_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && win_q == WLAST) |=> (bad_q == '0));
endmodule

// File: rtl/hsync_stretch.sv
module hsync_stretch #(
  parameter int STRETCH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic clr,
  output logic busy
);
  localparam int TW = $clog2(STRETCH + 1);
  localparam logic [TW-1:0] TLOAD = TW'(STRETCH);

  logic [TW-1:0] tmr_q, tmr_d;
  logic          tmr_en;

  always_comb begin
    tmr_d = tmr_q;
    if (clr)                tmr_d = '0;
    else if (load)          tmr_d = TLOAD;
    else if (tmr_q != '0)   tmr_d = tmr_q - 1'b1;
  end

  assign tmr_en = clr | load | (tmr_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmr_q <= '0;
    else if (tmr_en) tmr_q <= tmr_d;
  end

  assign busy = (tmr_q != '0);

  // R6: once running and not reloaded, the timer steps down by one
  p_steady_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load && !clr) |=> (tmr_q == $past(tmr_q) - 1'b1));

  // R6: a load always yields a busy flag on the next cycle
  p_load_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> busy);
endmodule

// File: rtl/hdr_block_sync.sv
module hdr_block_sync #(
  parameter int LOCK_CNT  = 64,
  parameter int WIN_LEN   = 64,
  parameter int ERR_LIMIT = 16,
  parameter int STRETCH   = 3
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       hdr_vld,
  input  logic [1:0] hdr,
  input  logic       man_slip,
  output logic       blk_lock,
  output logic       hdr_err,
  output logic       slip_req
);
  import hsync_pkg::*;

  logic     rst_n;
  sync_st_e st_q, st_d;
  logic     slip_q, slip_d;
  logic     man_q;
  logic     man_rise;
  logic     good;
  logic     searching;
  logic     acq_done;
  logic     loss;
  logic     err_load;
  logic     err_busy;

  hsync_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .arst_n    (arst_n),
    .rst_n_sync(rst_n)
  );

  assign good      = hdr_ok(hdr);
  assign searching = (st_q == ST_SEARCH);
  assign man_rise  = man_slip & ~man_q;

  hsync_acq #(.LOCK_CNT(LOCK_CNT)) u_acq (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (searching & hdr_vld),
    .ok     (good),
    .restart(man_rise),
    .done   (acq_done)
  );

  hsync_mon #(.WIN_LEN(WIN_LEN), .ERR_LIMIT(ERR_LIMIT)) u_mon (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (~searching & hdr_vld),
    .bad  (~good),
    .clr  (searching),
    .loss (loss)
  );

  assign err_load = ~searching & hdr_vld & ~good & ~loss;

  hsync_stretch #(.STRETCH(STRETCH)) u_str (
    .clk  (clk),
    .rst_n(rst_n),
    .load (err_load),
    .clr  (loss),
    .busy (err_busy)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_SEARCH: if (acq_done) st_d = ST_LOCKED;
      ST_LOCKED: if (loss)     st_d = ST_SEARCH;
      default:                 st_d = ST_SEARCH;
    endcase
  end

  assign slip_d = (searching & hdr_vld & ~good) | loss | man_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_SEARCH;
      slip_q <= 1'b0;
      man_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      slip_q <= slip_d;
      man_q  <= man_slip;
    end
  end

  assign blk_lock = (st_q == ST_LOCKED);
  assign hdr_err  = err_busy;
  assign slip_req = slip_q;

  // R2: lock can only appear right after a present, well-formed header
  p_lock_after_good_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blk_lock) |-> ($past(hdr_vld) && hdr_ok($past(hdr))));

  // R3: a bad header while searching is always answered by a slip
  p_search_bad_slip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_lock && hdr_vld && !hdr_ok(hdr)) |=> slip_req);

  // R4: losing lock always comes with a slip request
  p_loss_slips_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blk_lock) |-> slip_req);

  // R7: no error flag without lock
  p_err_needs_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err |-> blk_lock);

  // R8: a manual rising edge yields a slip on the next cycle
  p_man_slip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(man_slip) |=> slip_req);

  // R9: without a header strobe the lock state cannot move
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_vld |=> $stable(blk_lock));
endmodule

// File: tb/sim_hdr_block_sync.sv
`timescale 1ns/1ps
module sim_hdr_block_sync;
  logic       clk = 1'b0;
  logic       arst_n;
  logic       hdr_vld;
  logic [1:0] hdr;
  logic       man_slip;
  logic       blk_lock;
  logic       hdr_err;
  logic       slip_req;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  hdr_block_sync u0 (
    .clk     (clk),
    .arst_n  (arst_n),
    .hdr_vld (hdr_vld),
    .hdr     (hdr),
    .man_slip(man_slip),
    .blk_lock(blk_lock),
    .hdr_err (hdr_err),
    .slip_req(slip_req)
  );

  // fields: {vld, hdr[1:0], expected slip_req}; applied while searching
  localparam logic [3:0] VEC [0:7] = '{
    4'b1_01_0, 4'b1_10_0, 4'b1_00_1, 4'b1_11_1,
    4'b0_00_0, 4'b0_11_0, 4'b1_10_0, 4'b1_00_1
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] h, input logic m);
    @(negedge clk);
    hdr_vld  = v;
    hdr      = h;
    man_slip = m;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    arst_n = 1'b0; hdr_vld = 1'b0; hdr = 2'b00; man_slip = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset lock", blk_lock, 1'b0);
    chk("R10 reset err", hdr_err, 1'b0);
    chk("R10 reset slip", slip_req, 1'b0);
    @(negedge clk); arst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 / R9 table walk in search
    for (int i = 0; i < 8; i++) begin
      step(VEC[i][3], VEC[i][2:1], 1'b0);
      chk($sformatf("R1 R9 vector %0d slip", i), slip_req, VEC[i][0]);
      chk($sformatf("R9 vector %0d lock", i), blk_lock, 1'b0);
    end

    // R8 manual slip restarts search count; R2 acquisition point
    for (int i = 0; i < 40; i++) step(1'b1, 2'b01, 1'b0);
    step(1'b1, 2'b01, 1'b1);
    chk("R8 rise slip", slip_req, 1'b1);
    for (int i = 1; i <= 63; i++) begin
      step(1'b1, (i % 2) ? 2'b10 : 2'b01, (i == 1));
      if (i == 1) chk("R8 held no second slip", slip_req, 1'b0);
    end
    chk("R2 R8 no lock at 63", blk_lock, 1'b0);
    step(1'b1, 2'b01, 1'b0);
    chk("R2 lock at 64", blk_lock, 1'b1);

    // R6 stretch: headers 1..4 of window 1
    step(1'b1, 2'b00, 1'b0);
    chk("R6 err c1", hdr_err, 1'b1);
    chk("R6 lock kept", blk_lock, 1'b1);
    step(1'b1, 2'b01, 1'b0); chk("R6 err c2", hdr_err, 1'b1);
    step(1'b1, 2'b01, 1'b0); chk("R6 err c3", hdr_err, 1'b1);
    step(1'b1, 2'b01, 1'b0); chk("R6 err gone", hdr_err, 1'b0);
    // R6 retrigger: headers 5..10
    step(1'b1, 2'b11, 1'b0);
    step(1'b1, 2'b01, 1'b0);
    step(1'b1, 2'b11, 1'b0);
    step(1'b1, 2'b01, 1'b0);
    step(1'b1, 2'b01, 1'b0); chk("R6 retrigger still high", hdr_err, 1'b1);
    step(1'b1, 2'b01, 1'b0); chk("R6 retrigger ends", hdr_err, 1'b0);
    // finish window 1 (10 used)
    for (int i = 0; i < 54; i++) step(1'b1, 2'b10, 1'b0);

    // R5 window 2: 15 bad then fill
    for (int i = 0; i < 15; i++) step(1'b1, 2'b00, 1'b0);
    chk("R5 R4 15 bad keep lock", blk_lock, 1'b1);
    for (int i = 0; i < 49; i++) step(1'b1, 2'b01, 1'b0);

    // R4 window 3: 15 bad keep lock, 16th drops it
    for (int i = 0; i < 15; i++) step(1'b1, 2'b11, 1'b0);
    chk("R5 errors not carried across windows", blk_lock, 1'b1);
    step(1'b1, 2'b11, 1'b0);
    chk("R4 16th bad drops lock", blk_lock, 1'b0);
    chk("R4 loss slip", slip_req, 1'b1);
    chk("R7 no err after loss", hdr_err, 1'b0);
    step(1'b1, 2'b01, 1'b0);
    chk("R7 err stays low", hdr_err, 1'b0);
    chk("R4 slip one cycle", slip_req, 1'b0);

    // R3 search restart after bad header
    for (int i = 0; i < 10; i++) step(1'b1, 2'b01, 1'b0);
    step(1'b1, 2'b11, 1'b0);
    chk("R3 bad slip", slip_req, 1'b1);
    for (int i = 0; i < 63; i++) step(1'b1, 2'b10, 1'b0);
    chk("R3 slip single cycle", slip_req, 1'b0);
    chk("R3 count restarted", blk_lock, 1'b0);
    step(1'b1, 2'b10, 1'b0);
    chk("R3 R2 relock", blk_lock, 1'b1);

    // R8 manual slip under lock
    step(1'b1, 2'b01, 1'b1);
    chk("R8 slip in lock", slip_req, 1'b1);
    chk("R8 lock unaffected", blk_lock, 1'b1);
    step(1'b1, 2'b01, 1'b0);

    // R10 asynchronous reset while locked and flagging
    step(1'b1, 2'b00, 1'b0);
    chk("R10 pre err", hdr_err, 1'b1);
    @(negedge clk); arst_n = 1'b0;
    #1;
    chk("R10 async lock", blk_lock, 1'b0);
    chk("R10 async err", hdr_err, 1'b0);
    @(negedge clk); arst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R10 lock after release", blk_lock, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule